// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block sits between a UART receiver and its receive FIFO, and beside the transmitter. It handles in-band software flow control. Every received byte comes in on a valid/ready stream. The block either consumes the byte as a flow-control character or forwards it unchanged on a second valid/ready stream toward the FIFO. A received stop character raises a transmit-halt flag for the transmitter, and a received resume character clears it. In the other direction, the block watches the receive FIFO fill level against a trigger threshold. When the level reaches the threshold, it requests a stop character (or a pair of them) on a third valid/ready stream. When the level falls back below the threshold, it requests a resume character (or pair).

A 4-bit mode field configures the block. Bits [3:2] choose the transmit character set and bits [1:0] choose the receive comparison set, and the two halves are independent. Four programmed characters are supplied: two resume values (ON-A, ON-B) and two stop values (OFF-A, OFF-B). Bit 0 of each programmed character is compared with bit 0 of the received byte, which is the first bit on the line. A separate special-character mode, which works only while the whole mode field is zero, flags any received byte equal to OFF-B and still forwards that byte.

Back-pressure rules: the receive stream is ready whenever the forward register is empty or is being drained in the same cycle. A valid forward or flow-request output holds its data unchanged until the consumer takes it. Control and status pins are plain levels.

Top module: `uart_xonxoff_ctl`

## Requirements
- R1: `rx_ready` equals `!fwd_valid || fwd_ready`. While `fwd_valid` is high and `fwd_ready` is low, `fwd_valid` stays high and `fwd_data` does not change.
- R2: With receive mode `fc_mode[1:0]`=00, every accepted byte is forwarded unchanged and in order, and `tx_halt` is 0 one cycle later.
- R3: With receive mode 10 (compare ON-A/OFF-A) or 01 (compare ON-B/OFF-B), an accepted byte equal to the selected stop character sets `tx_halt` in the next cycle, and one equal to the selected resume character clears it. Matched bytes are not forwarded, other bytes are, and the stop comparison has priority.
- R4: With receive mode 11, OFF-A followed by OFF-B sets `tx_halt` and ON-A followed by ON-B clears it. Both bytes of a completed pair are consumed, and `tx_halt` does not change after the first byte alone.
- R5: In receive mode 11, if the byte after a held first character is not its partner, the held byte is discarded, the tracker returns to idle, and the breaking byte is evaluated afresh (it may forward, or start a new pair).
- R6: With `spc_det_en`=1 and `fc_mode`=0000, an accepted byte equal to OFF-B is forwarded and sets `spc_flag` in the next cycle. The flag stays set until a `spc_clr` pulse, and a new match in the same cycle as a clear wins.
- R7: When `fc_mode` is non-zero, `spc_det_en` has no effect and `spc_flag` does not set.
- R8: Transmit mode `fc_mode[3:2]`=10 requests OFF-A/ON-A, 01 requests OFF-B/ON-B, and 11 requests the pair OFF-A then OFF-B (or ON-A then ON-B). Mode 00 starts no request.
- R9: A stop request starts once when `rx_fill >= rx_trig` first holds, and a resume request starts once when `rx_fill < rx_trig` first holds after that. No request repeats while the same condition persists.
- R10: While `txf_valid` is high and `txf_ready` is low, `txf_valid` stays high and `txf_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_mode | input | 4 | [3:2] transmit set, [1:0] receive set (10=A, 01=B, 11=pair, 00=off) |
| spc_det_en | input | 1 | Special-character detect enable |
| xon_a | input | DATA_W | Resume character A |
| xon_b | input | DATA_W | Resume character B |
| xoff_a | input | DATA_W | Stop character A |
| xoff_b | input | DATA_W | Stop character B, also the special character |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block can accept a received byte |
| rx_data | input | DATA_W | Received byte, bit 0 first on the line |
| fwd_valid | output | 1 | Forwarded byte valid toward FIFO |
| fwd_ready | input | 1 | FIFO takes forwarded byte |
| fwd_data | output | DATA_W | Forwarded byte |
| spc_clr | input | 1 | Clear pulse for the special flag |
| spc_flag | output | 1 | Special character seen |
| tx_halt | output | 1 | Transmitter must pause |
| rx_fill | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Fill trigger threshold |
| txf_valid | output | 1 | Flow character request valid |
| txf_ready | input | 1 | Transmitter takes flow character |
| txf_data | output | DATA_W | Flow character to send |

## Verification
A pair tracker stuck in a half-matched state shows at the next received byte. That byte goes missing from the forward stream, or `tx_halt` moves on a lone second character, one cycle after the handshake. A wrong record of which request was last sent shows up as either a repeated stop/resume character on `txf_data` within a few cycles of a level change, or a missing one. A bad halt or special-flag register is visible on its pin one cycle after the byte that should have moved it. The bench mixes directed pair-breaking and back-pressure cases with seeded random byte streams and level walks, and compares against a model of these rules.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  // Two-bit selector codes shared by the transmit and receive halves
  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_SETB = 2'b01;
  localparam logic [1:0] FC_SETA = 2'b10;
  localparam logic [1:0] FC_PAIR = 2'b11;

  typedef enum logic [1:0] {PT_IDLE, PT_ON_A, PT_OFF_A} pair_st_e;
  typedef enum logic [1:0] {TQ_IDLE, TQ_FIRST, TQ_SECOND} txq_st_e;
endpackage

// File: rtl/xfc_rx_match.sv
module xfc_rx_match
  import xfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rx_sel,
  input  logic              spc_active,
  input  logic [DATA_W-1:0] xon_a,
  input  logic [DATA_W-1:0] xon_b,
  input  logic [DATA_W-1:0] xoff_a,
  input  logic [DATA_W-1:0] xoff_b,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              spc_clr,
  output logic              spc_flag,
  output logic              tx_halt
);
  pair_st_e          pst_q, pst_eff, pst_n;
  logic              halt_q, halt_n;
  logic              drop, fresh, accept;
  logic              fwd_v_q, spc_q;
  logic [DATA_W-1:0] fwd_d_q;

  assign rx_ready = !fwd_v_q || fwd_ready;
  assign accept   = rx_valid && rx_ready;
  assign pst_eff  = (rx_sel == FC_PAIR) ? pst_q : PT_IDLE;

  // Classify the byte on the input against the selected characters
  always_comb begin
    drop   = 1'b0;
    fresh  = 1'b0;
    halt_n = halt_q;
    pst_n  = pst_eff;
    case (pst_eff)
      PT_ON_A: begin
        pst_n = PT_IDLE;
        if (rx_data == xon_b) begin
          drop   = 1'b1;
          halt_n = 1'b0;
        end else begin
          fresh = 1'b1;
        end
      end
      PT_OFF_A: begin
        pst_n = PT_IDLE;
        if (rx_data == xoff_b) begin
          drop   = 1'b1;
          halt_n = 1'b1;
        end else begin
          fresh = 1'b1;
        end
      end
      default: fresh = 1'b1;
    endcase
    if (fresh) begin
      case (rx_sel)
        FC_SETA: begin
          if (rx_data == xoff_a) begin
            drop = 1'b1; halt_n = 1'b1;
          end else if (rx_data == xon_a) begin
            drop = 1'b1; halt_n = 1'b0;
          end
        end
        FC_SETB: begin
          if (rx_data == xoff_b) begin
            drop = 1'b1; halt_n = 1'b1;
          end else if (rx_data == xon_b) begin
            drop = 1'b1; halt_n = 1'b0;
          end
        end
        FC_PAIR: begin
          if (rx_data == xoff_a) begin
            drop = 1'b1; pst_n = PT_OFF_A;
          end else if (rx_data == xon_a) begin
            drop = 1'b1; pst_n = PT_ON_A;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      pst_q   <= PT_IDLE;
      fwd_v_q <= 1'b0;
      fwd_d_q <= '0;
      spc_q   <= 1'b0;
    end else begin
      if (rx_sel == FC_NONE)  halt_q <= 1'b0;
      else if (accept)        halt_q <= halt_n;
      if (rx_sel != FC_PAIR)  pst_q <= PT_IDLE;
      else if (accept)        pst_q <= pst_n;
      if (accept && !drop) begin
        fwd_v_q <= 1'b1;
        fwd_d_q <= rx_data;
      end else if (fwd_ready) begin
        fwd_v_q <= 1'b0;
      end
      if (accept && spc_active && rx_data == xoff_b) spc_q <= 1'b1;
      else if (spc_clr)                              spc_q <= 1'b0;
    end
  end

  assign fwd_valid = fwd_v_q;
  assign fwd_data  = fwd_d_q;
  assign spc_flag  = spc_q;
  assign tx_halt   = halt_q;

  assert_fwd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data)));
  assert_halt_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel == FC_NONE) |=> !tx_halt);
  assert_stop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_sel == FC_SETA && rx_data == xoff_a) |=> (tx_halt && !fwd_valid));
  assert_pair_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_sel == FC_PAIR && pst_q == PT_OFF_A && rx_data == xoff_b) |=> tx_halt);
  assert_spc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_flag && !spc_clr) |=> spc_flag);
endmodule

// File: rtl/xfc_tx_req.sv
module xfc_tx_req
  import xfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tx_sel,
  input  logic [LVL_W-1:0]  fill_lvl,
  input  logic [LVL_W-1:0]  trig_lvl,
  input  logic [DATA_W-1:0] xon_a,
  input  logic [DATA_W-1:0] xon_b,
  input  logic [DATA_W-1:0] xoff_a,
  input  logic [DATA_W-1:0] xoff_b,
  output logic              txf_valid,
  input  logic              txf_ready,
  output logic [DATA_W-1:0] txf_data
);
  txq_st_e           st_q;
  logic              sent_off_q, pair_q, above;
  logic [DATA_W-1:0] b0_q, b1_q;

  assign above = (fill_lvl >= trig_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= TQ_IDLE;
      sent_off_q <= 1'b0;
      pair_q     <= 1'b0;
      b0_q       <= '0;
      b1_q       <= '0;
    end else begin
      case (st_q)
        TQ_IDLE: begin
          if (tx_sel == FC_NONE) begin
            sent_off_q <= 1'b0;
          end else if (above != sent_off_q) begin
            sent_off_q <= above;
            pair_q     <= (tx_sel == FC_PAIR);
            if (above) begin
              b0_q <= (tx_sel == FC_SETB) ? xoff_b : xoff_a;
              b1_q <= xoff_b;
            end else begin
              b0_q <= (tx_sel == FC_SETB) ? xon_b : xon_a;
              b1_q <= xon_b;
            end
            st_q <= TQ_FIRST;
          end
        end
        TQ_FIRST:  if (txf_ready) st_q <= pair_q ? TQ_SECOND : TQ_IDLE;
        TQ_SECOND: if (txf_ready) st_q <= TQ_IDLE;
        default:   st_q <= TQ_IDLE;
      endcase
    end
  end

  assign txf_valid = (st_q != TQ_IDLE);
  assign txf_data  = (st_q == TQ_SECOND) ? b1_q : b0_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_valid && !txf_ready) |=> (txf_valid && $stable(txf_data)));
  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == FC_NONE && !txf_valid) |=> !txf_valid);
  assert_one_per_cross_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txf_valid) |-> (sent_off_q != $past(sent_off_q)));
endmodule

// File: rtl/uart_xonxoff_ctl.sv
module uart_xonxoff_ctl
  import xfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fc_mode,
  input  logic              spc_det_en,
  input  logic [DATA_W-1:0] xon_a,
  input  logic [DATA_W-1:0] xon_b,
  input  logic [DATA_W-1:0] xoff_a,
  input  logic [DATA_W-1:0] xoff_b,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              spc_clr,
  output logic              spc_flag,
  output logic              tx_halt,
  input  logic [LVL_W-1:0]  rx_fill,
  input  logic [LVL_W-1:0]  rx_trig,
  output logic              txf_valid,
  input  logic              txf_ready,
  output logic [DATA_W-1:0] txf_data
);
  logic spc_active;
  // Special detect only when every flow-control selector is off
  assign spc_active = spc_det_en && (fc_mode == 4'b0000);

  xfc_rx_match #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_sel(fc_mode[1:0]), .spc_active(spc_active),
    .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a), .xoff_b(xoff_b),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
    .spc_clr(spc_clr), .spc_flag(spc_flag), .tx_halt(tx_halt)
  );

  xfc_tx_req #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_sel(fc_mode[3:2]),
    .fill_lvl(rx_fill), .trig_lvl(rx_trig),
    .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a), .xoff_b(xoff_b),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data)
  );

  assert_spc_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!spc_active && !spc_flag) |=> !spc_flag);
endmodule

// File: tb/uart_xonxoff_ctl_test.sv
module uart_xonxoff_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ONA = 8'h11, ONB = 8'h12, OFFA = 8'h13, OFFB = 8'h14;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, spc_det_en, rx_valid, rx_ready, fwd_valid, fwd_ready;
  logic       spc_clr, spc_flag, tx_halt, txf_valid, txf_ready;
  logic [3:0] fc_mode;
  logic [7:0] rx_data, fwd_data, txf_data, rx_fill, rx_trig;
  logic       rand_ready, fix_ready;

  uart_xonxoff_ctl uut (
    .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .spc_det_en(spc_det_en),
    .xon_a(ONA), .xon_b(ONB), .xoff_a(OFFA), .xoff_b(OFFB),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
    .spc_clr(spc_clr), .spc_flag(spc_flag), .tx_halt(tx_halt),
    .rx_fill(rx_fill), .rx_trig(rx_trig),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data)
  );

  int errs = 0, checks = 0;
  logic m_halt = 1'b0, m_spc = 1'b0, m_sent = 1'b0;
  int   m_pst = 0;
  logic [7:0] exp_f [0:1023];
  logic [7:0] got_f [0:1023];
  logic [7:0] exp_t [0:1023];
  logic [7:0] got_t [0:1023];
  int nexp_f = 0, ngot_f = 0, nexp_t = 0, ngot_t = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Forward-ready driver and stream monitors
  initial begin
    fwd_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      fwd_ready = rand_ready ? ($urandom % 4 != 0) : fix_ready;
    end
  end
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fwd_valid && fwd_ready) begin got_f[ngot_f % 1024] = fwd_data; ngot_f++; end
      if (rst_n && txf_valid && txf_ready) begin got_t[ngot_t % 1024] = txf_data; ngot_t++; end
    end
  end

  function automatic logic [7:0] tx_char(input logic [1:0] tm, input bit off, input bit second);
    if (second) return off ? OFFB : ONB;
    if (tm == 2'b01) return off ? OFFB : ONB;
    return off ? OFFA : ONA;
  endfunction

  task automatic push_f(input logic [7:0] b);
    exp_f[nexp_f % 1024] = b; nexp_f++;
  endtask

  task automatic tx_eval();
    logic [1:0] tm;
    bit ab;
    tm = fc_mode[3:2];
    if (tm == 2'b00) m_sent = 1'b0;
    else begin
      ab = (rx_fill >= rx_trig);
      if (ab != m_sent) begin
        exp_t[nexp_t % 1024] = tx_char(tm, ab, 1'b0); nexp_t++;
        if (tm == 2'b11) begin exp_t[nexp_t % 1024] = tx_char(tm, ab, 1'b1); nexp_t++; end
      end
      m_sent = ab;
    end
  endtask

  // Receive-side reference model of the requirements
  task automatic m_rx(input logic [7:0] b);
    logic [1:0] rm;
    bit done;
    rm = fc_mode[1:0];
    done = 0;
    if (rm == 2'b11 && m_pst == 1) begin
      m_pst = 0;
      if (b == ONB) begin m_halt = 0; done = 1; end
    end else if (rm == 2'b11 && m_pst == 2) begin
      m_pst = 0;
      if (b == OFFB) begin m_halt = 1; done = 1; end
    end
    if (!done) begin
      case (rm)
        2'b10: if (b == OFFA) m_halt = 1; else if (b == ONA) m_halt = 0; else push_f(b);
        2'b01: if (b == OFFB) m_halt = 1; else if (b == ONB) m_halt = 0; else push_f(b);
        2'b11: if (b == OFFA) m_pst = 2; else if (b == ONA) m_pst = 1; else push_f(b);
        default: push_f(b);
      endcase
    end
    if (spc_det_en && fc_mode == 4'b0000 && b == OFFB) m_spc = 1;
  endtask

  task automatic set_mode(input logic [3:0] m, input logic se);
    @(posedge clk); #1;
    fc_mode = m; spc_det_en = se;
    if (m[1:0] != 2'b11) m_pst = 0;
    if (m[1:0] == 2'b00) m_halt = 0;
    tx_eval();
    repeat (5) @(posedge clk);
  endtask

  task automatic set_level(input logic [7:0] l);
    @(posedge clk); #1;
    rx_fill = l;
    tx_eval();
    repeat (5) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    chk(rx_ready == (!fwd_valid || fwd_ready), "R1", "rx_ready rule", rx_ready, !fwd_valid || fwd_ready);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    m_rx(b);
    @(negedge clk);
    chk(tx_halt == m_halt, req, "tx_halt", tx_halt, m_halt);
    chk(spc_flag == m_spc, req, "spc_flag", spc_flag, m_spc);
  endtask

  task automatic pulse_clr(input string req);
    @(posedge clk); #1; spc_clr = 1'b1;
    @(posedge clk); #1; spc_clr = 1'b0;
    m_spc = 0;
    @(negedge clk);
    chk(spc_flag == 1'b0, req, "spc_flag after clear", spc_flag, 0);
  endtask

  task automatic check_streams(input string req);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(ngot_f == nexp_f, req, "forwarded count", ngot_f, nexp_f);
    for (int i = 0; i < nexp_f && i < ngot_f; i++)
      chk(got_f[i % 1024] == exp_f[i % 1024], req, "forwarded byte", got_f[i % 1024], exp_f[i % 1024]);
    chk(ngot_t == nexp_t, req, "flow request count", ngot_t, nexp_t);
    for (int i = 0; i < nexp_t && i < ngot_t; i++)
      chk(got_t[i % 1024] == exp_t[i % 1024], req, "flow request byte", got_t[i % 1024], exp_t[i % 1024]);
    ngot_f = 0; nexp_f = 0; ngot_t = 0; nexp_t = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 0; fc_mode = 4'b0; spc_det_en = 0; rx_valid = 0; rx_data = 0;
    spc_clr = 0; rx_fill = 0; rx_trig = 8; txf_ready = 1; rand_ready = 0; fix_ready = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(tx_halt == 0, "R2", "reset tx_halt", tx_halt, 0);
    chk(spc_flag == 0, "R6", "reset spc_flag", spc_flag, 0);
    chk(fwd_valid == 0, "R1", "reset fwd_valid", fwd_valid, 0);
    chk(txf_valid == 0, "R8", "reset txf_valid", txf_valid, 0);
    chk(rx_ready == 1, "R1", "reset rx_ready", rx_ready, 1);

    // R2: no receive comparison
    send_byte(OFFA, "R2"); send_byte(ONA, "R2"); send_byte(8'h41, "R2");
    check_streams("R2");
    // R3: single-character sets
    set_mode(4'b0010, 0);
    send_byte(8'h41, "R3"); send_byte(OFFA, "R3"); send_byte(OFFB, "R3"); send_byte(ONA, "R3");
    set_mode(4'b0001, 0);
    send_byte(OFFB, "R3"); send_byte(OFFA, "R3"); send_byte(ONB, "R3");
    check_streams("R3");
    // R4: paired comparison
    set_mode(4'b0011, 0);
    send_byte(OFFA, "R4"); send_byte(OFFB, "R4"); send_byte(ONA, "R4"); send_byte(ONB, "R4");
    check_streams("R4");
    // R5: broken pairs
    send_byte(OFFA, "R5"); send_byte(8'h55, "R5");
    send_byte(ONA, "R5"); send_byte(OFFA, "R5"); send_byte(OFFB, "R5");
    send_byte(ONA, "R5"); send_byte(ONA, "R5"); send_byte(ONB, "R5");
    check_streams("R5");
    // R6: special character detect
    set_mode(4'b0000, 1);
    send_byte(8'h20, "R6"); send_byte(OFFB, "R6"); send_byte(8'h21, "R6");
    pulse_clr("R6");
    send_byte(OFFB, "R6");
    @(posedge clk); #1; spc_clr = 1'b1; rx_valid = 1'b1; rx_data = OFFB;
    @(posedge clk); #1; spc_clr = 1'b0; rx_valid = 1'b0; push_f(OFFB);
    @(negedge clk);
    chk(spc_flag == 1'b1, "R6", "match wins over clear", spc_flag, 1);
    pulse_clr("R6");
    check_streams("R6");
    // R7: detect gated off by non-zero mode
    set_mode(4'b1000, 1);
    send_byte(OFFB, "R7");
    set_mode(4'b0001, 1);
    send_byte(OFFB, "R7"); send_byte(ONB, "R7");
    check_streams("R7");
    // R1: back-pressure on the forward stream
    set_mode(4'b0000, 0);
    @(posedge clk); #1; fix_ready = 0;
    send_byte(8'h61, "R1");
    @(posedge clk); #1; rx_valid = 1'b1; rx_data = 8'h62;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fwd_valid == 1 && fwd_data == 8'h61, "R1", "held forward byte", fwd_data, 8'h61);
      chk(rx_ready == 0, "R1", "rx_ready stalled", rx_ready, 0);
    end
    @(posedge clk); #1; rx_valid = 1'b0; fix_ready = 1;
    send_byte(8'h62, "R1");
    check_streams("R1");

    // Random receive traffic with random forward back-pressure
    rand_ready = 1;
    for (int blk = 0; blk < 20; blk++) begin
      set_mode({2'b00, 2'($urandom % 4)}, 1'($urandom % 2));
      if (blk % 5 == 0) set_mode(4'b0000, 1);
      for (int n = 0; n < 20; n++) begin
        logic [7:0] b;
        case ($urandom % 6)
          0: b = ONA; 1: b = ONB; 2: b = OFFA; 3: b = OFFB;
          default: b = 8'($urandom);
        endcase
        send_byte(b, "R3/R4/R5 random");
        if ($urandom % 10 == 0) pulse_clr("R6");
      end
    end
    rand_ready = 0;
    check_streams("R2/R3/R4/R5 random stream");

    // R8/R9: transmit requests on level crossings
    set_mode(4'b0000, 0);
    set_level(8'd20); set_level(8'd3);
    check_streams("R8 mode off");
    set_mode(4'b1000, 0);
    set_level(8'd10); set_level(8'd12); set_level(8'd8);
    set_level(8'd3); set_level(8'd2);
    check_streams("R9 set A once");
    set_mode(4'b0100, 0);
    set_level(8'd9); set_level(8'd1);
    check_streams("R8 set B");
    set_mode(4'b1100, 0);
    set_level(8'd30); set_level(8'd25); set_level(8'd7);
    check_streams("R8 pair");
    // R10: request held under back-pressure
    set_mode(4'b1000, 0);
    @(posedge clk); #1; txf_ready = 0; rx_fill = 8'd20; tx_eval();
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(txf_valid == 1 && txf_data == OFFA, "R10", "held request", txf_data, OFFA);
    end
    @(posedge clk); #1; txf_ready = 1;
    set_level(8'd21);
    check_streams("R10");
    // Random level walk
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0) set_mode({2'($urandom % 4), 2'b00}, 0);
      set_level(8'($urandom % 16));
    end
    check_streams("R8/R9 random");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule